// File: doc/BRIEF.md
# Burst Packetizer with Transmit-Time Stamping

This block sits on the path from a sample-processing datapath to a radio transmit port. It passes the sample stream straight through and decides where the outgoing packets start and end. A packet closes when a fixed number of samples has been accepted. It also closes early on the sample that ends a burst, and that sample additionally raises the end-of-burst flag. The sample counter then starts again from zero.

Each outgoing packet can carry a transmit time. The block latches the receive time from the first sample of every incoming packet that carries one. It adds a programmable offset and presents the result, with a has-time flag, on the first sample of the next outgoing packet. This schedules the retransmission a fixed interval after reception. Ready backpressure flows straight from the transmit side to the source. The block adds no buffering and no cycles of latency.

Top module: `burst_packetizer`

## Requirements
- R1: `out_data` and `out_valid` follow `in_data` and `in_valid` in the same cycle, and `in_ready` follows `out_ready` in the same cycle.
- R2: A sample is accepted when `in_valid` and `out_ready` are both high. `out_last` is high on a valid sample that is the PKT_LEN-th accepted sample since the current output packet began (default 256).
- R3: A valid sample with both `in_eob` and `in_last` high is a burst end. On it, `out_eob` and `out_last` are both high. `in_eob` without `in_last` has no effect, and `out_eob` is never high on any other sample.
- R4: The sample count advances only on accepted samples. After any accepted sample with `out_last` high, the next accepted sample is the first of a new output packet, counted from zero.
- R5: The receive time is latched from `in_time` on the first valid sample of each input packet when `in_has_time` is high. The first input packet starts after reset, and every later one starts after an accepted sample with `in_last` high. The latched time stays pending until an output packet uses it. A newer capture overwrites a pending time.
- R6: `out_has_time` is high only on the first sample of an output packet, and only when a time is pending or is being captured on that same sample. Accepting that sample consumes the pending time.
- R7: When `out_has_time` is high, `out_time` equals the pending receive time plus `tx_offset`, modulo 2^64. When `out_has_time` is low, `out_time` is zero.
- R8: While a first sample that carries a time is stalled (`out_valid` high, `out_ready` low), `out_has_time` and `out_time` keep the values they had in the first stalled cycle, even if `tx_offset` changes.
- R9: Synchronous active-high reset clears the sample count and the pending time. After reset, the next sample starts a new input packet and a new output packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Incoming sample |
| in_valid | input | 1 | Incoming sample valid |
| in_ready | output | 1 | Backpressure to the source (same as out_ready) |
| in_last | input | 1 | Last sample of an input packet |
| in_eob | input | 1 | Burst-end marker, effective together with in_last |
| in_has_time | input | 1 | in_time is meaningful on this sample |
| in_time | input | 64 | Receive time of the input packet |
| tx_offset | input | 64 | Offset added to the receive time |
| out_data | output | DATA_W | Outgoing sample |
| out_valid | output | 1 | Outgoing sample valid |
| out_ready | input | 1 | Transmit side ready |
| out_last | output | 1 | Last sample of an output packet |
| out_eob | output | 1 | Last sample of a burst |
| out_has_time | output | 1 | out_time is meaningful on this sample |
| out_time | output | 64 | Scheduled transmit time |

## Verification
The embedded properties assume the source keeps to the usual streaming rule. Once `in_valid` is high, the sample and all its side-band fields stay unchanged until it is accepted. The stall-stability check for the stamped time relies on this rule. The bench only produces stalls by holding one fully formed sample on the inputs while `out_ready` stays low. It changes `tx_offset` only during such stalls or between samples, and it drops `in_valid` only in idle gaps between accepted samples.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

    localparam int TS_W = 64;

    typedef logic [TS_W-1:0] ts_t;

    // Side-band fields travelling with each incoming sample.
    typedef struct packed {
        logic last;
        logic eob;
        logic has_time;
    } in_side_t;

    // Side-band fields travelling with each outgoing sample.
    typedef struct packed {
        logic last;
        logic eob;
        logic has_time;
        ts_t  stamp;
    } out_side_t;

    function automatic ts_t ts_add(input ts_t base, input ts_t offset);
        return base + offset;
    endfunction

    function automatic logic is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/pkt_beat_counter.sv
module pkt_beat_counter #(
    parameter int PKT_LEN = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic burst_end,
    output logic pkt_first,
    output logic pkt_last
);
    import pkt_pkg::*;

    localparam int CNT_W = (PKT_LEN > 2) ? $clog2(PKT_LEN) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PKT_LEN - 1);

    logic [CNT_W-1:0] count;
    logic             at_limit;

    generate
        if (is_pow2(PKT_LEN)) begin : g_pow2
            assign at_limit = &count;
        end else begin : g_any
            assign at_limit = (count == LIMIT);
        end
    endgenerate

    assign pkt_first = (count == '0);
    assign pkt_last  = at_limit || burst_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (fire) begin
            if (pkt_last) count <= '0;
            else          count <= count + 1'b1;
        end
    end

    p_count_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(count));

    p_count_restart_r4: assert property (@(posedge clk) disable iff (rst)
        fire && pkt_last |=> count == '0);

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        fire && !pkt_last |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/pkt_rx_time.sv
module pkt_rx_time (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          fire,
    input  logic          in_last,
    input  logic          in_has_time,
    input  pkt_pkg::ts_t  in_time,
    input  logic          consume,
    output logic          ts_avail,
    output pkt_pkg::ts_t  base_time
);
    import pkt_pkg::*;

    logic in_first;
    logic pending;
    ts_t  rx_time;
    logic cap;

    assign cap       = in_valid && in_first && in_has_time;
    assign ts_avail  = pending || cap;
    assign base_time = cap ? in_time : rx_time;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_first <= 1'b1;
            pending  <= 1'b0;
            rx_time  <= '0;
        end else if (fire) begin
            in_first <= in_last;
            if (cap) begin
                rx_time <= in_time;
                pending <= !consume;
            end else if (consume) begin
                pending <= 1'b0;
            end
        end
    end

    p_pending_clear_r6: assert property (@(posedge clk) disable iff (rst)
        consume && !cap |=> !pending);

    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        fire && cap && !consume |=> pending && (rx_time == $past(in_time)));

    p_pending_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(pending) && $stable(rx_time));

endmodule

// File: rtl/pkt_tx_stamp.sv
module pkt_tx_stamp (
    input  logic          clk,
    input  logic          rst,
    input  logic          present,
    input  logic          fire,
    input  pkt_pkg::ts_t  base_time,
    input  pkt_pkg::ts_t  offset,
    output pkt_pkg::ts_t  stamp
);
    import pkt_pkg::*;

    logic hold_vld;
    ts_t  hold_time;
    ts_t  sum;

    assign sum   = ts_add(base_time, offset);
    assign stamp = hold_vld ? hold_time : sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld  <= 1'b0;
            hold_time <= '0;
        end else if (fire) begin
            hold_vld  <= 1'b0;
        end else if (present && !hold_vld) begin
            hold_vld  <= 1'b1;
            hold_time <= sum;
        end
    end

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        present && !fire |=> $stable(stamp));

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        fire |=> !hold_vld);

endmodule

// File: rtl/burst_packetizer.sv
module burst_packetizer #(
    parameter int DATA_W  = 32,
    parameter int PKT_LEN = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_last,
    input  logic              in_eob,
    input  logic              in_has_time,
    input  logic [63:0]       in_time,
    input  logic [63:0]       tx_offset,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_last,
    output logic              out_eob,
    output logic              out_has_time,
    output logic [63:0]       out_time
);
    import pkt_pkg::*;

    in_side_t  side_in;
    out_side_t side_out;

    logic fire;
    logic burst_end;
    logic pkt_first;
    logic pkt_last;
    logic ts_avail;
    logic present;
    logic consume;
    ts_t  base_time;
    ts_t  stamp;

    assign side_in = '{last: in_last, eob: in_eob, has_time: in_has_time};

    assign fire      = in_valid && out_ready;
    assign burst_end = side_in.eob && side_in.last;
    assign present   = in_valid && pkt_first && ts_avail;
    assign consume   = fire && pkt_first && ts_avail;

    pkt_beat_counter #(.PKT_LEN(PKT_LEN)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .burst_end (burst_end),
        .pkt_first (pkt_first),
        .pkt_last  (pkt_last)
    );

    pkt_rx_time u_rx (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .fire        (fire),
        .in_last     (side_in.last),
        .in_has_time (side_in.has_time),
        .in_time     (in_time),
        .consume     (consume),
        .ts_avail    (ts_avail),
        .base_time   (base_time)
    );

    pkt_tx_stamp u_stamp (
        .clk       (clk),
        .rst       (rst),
        .present   (present),
        .fire      (fire),
        .base_time (base_time),
        .offset    (tx_offset),
        .stamp     (stamp)
    );

    always_comb begin
        side_out.last     = in_valid && pkt_last;
        side_out.eob      = in_valid && burst_end;
        side_out.has_time = present;
        side_out.stamp    = present ? stamp : '0;
    end

    assign in_ready     = out_ready;
    assign out_data     = in_data;
    assign out_valid    = in_valid;
    assign out_last     = side_out.last;
    assign out_eob      = side_out.eob;
    assign out_has_time = side_out.has_time;
    assign out_time     = side_out.stamp;

    p_eob_last_r3: assert property (@(posedge clk) disable iff (rst)
        out_eob |-> out_last);

    p_time_on_valid_r6: assert property (@(posedge clk) disable iff (rst)
        out_has_time |-> out_valid);

    p_one_stamp_r6: assert property (@(posedge clk) disable iff (rst)
        out_has_time && out_valid && out_ready && !out_last |=> !out_has_time);

    p_stall_flag_r8: assert property (@(posedge clk) disable iff (rst)
        out_has_time && !out_ready |=> out_has_time);

    p_zero_time_r7: assert property (@(posedge clk) disable iff (rst)
        !out_has_time |-> out_time == '0);

endmodule

// File: tb/sim_burst_packetizer.sv
module sim_burst_packetizer;

    localparam int DW  = 32;
    localparam int PL  = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0, in_last = 1'b0, in_eob = 1'b0, in_has_time = 1'b0;
    logic [63:0]   in_time = '0, tx_offset = '0;
    logic          out_ready = 1'b0;
    logic          in_ready, out_valid, out_last, out_eob, out_has_time;
    logic [DW-1:0] out_data;
    logic [63:0]   out_time;

    always #2 clk = ~clk;

    burst_packetizer #(.DATA_W(DW), .PKT_LEN(PL)) u0 (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_last(in_last), .in_eob(in_eob), .in_has_time(in_has_time), .in_time(in_time),
        .tx_offset(tx_offset), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_last(out_last), .out_eob(out_eob), .out_has_time(out_has_time), .out_time(out_time)
    );

    int n_chk = 0, n_bad = 0;

    // Reference state
    int          m_cnt = 0;
    bit          m_in_first = 1;
    bit          m_pend = 0;
    logic [63:0] m_rx = '0;
    bit          m_hold = 0;
    logic [63:0] m_hold_t = '0;
    bit          stall_seen = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_in_first = 1; m_pend = 0; m_hold = 0;
    endtask

    // One cycle: inputs already driven; compare mid-cycle, then advance model at edge.
    task automatic cycle();
        bit          v, rdy, fire, be, cap, avail, e_last, e_eob, e_ht;
        logic [63:0] base, e_t;
        #1;
        v = in_valid; rdy = out_ready; fire = v && rdy;
        be     = in_eob && in_last;
        e_last = v && ((m_cnt == PL-1) || be);
        e_eob  = v && be;
        cap    = v && m_in_first && in_has_time;
        avail  = m_pend || cap;
        e_ht   = v && (m_cnt == 0) && avail;
        base   = cap ? in_time : m_rx;
        e_t    = e_ht ? (m_hold ? m_hold_t : base + tx_offset) : 64'd0;

        chk(out_data == in_data && out_valid == v && in_ready == rdy, "R1 passthrough",
            {out_data, out_valid, in_ready}, {in_data, v, rdy});
        chk(out_last == e_last, "R2/R4 last", out_last, e_last);
        chk(out_eob == e_eob, "R3 eob", out_eob, e_eob);
        chk(out_has_time == e_ht, "R6 has_time", out_has_time, e_ht);
        if (m_hold) chk(out_time == e_t, "R8 held time", out_time, e_t);
        else        chk(out_time == e_t, "R5/R7 time", out_time, e_t);
        if (m_hold) stall_seen = 1;

        @(posedge clk);
        if (fire) begin
            m_cnt = e_last ? 0 : m_cnt + 1;
            m_in_first = in_last;
            if (cap) begin m_rx = in_time; m_pend = !e_ht; end
            else if (e_ht) m_pend = 0;
            m_hold = 0;
        end else if (e_ht && !m_hold) begin
            m_hold = 1; m_hold_t = e_t;
        end
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 0; out_ready = ($urandom_range(0, 1) == 1);
            cycle();
        end
    endtask

    // Present one sample, stall it for 'st' cycles, then accept it.
    task automatic beat(input bit lst, input bit eob, input bit ht, input logic [63:0] t,
                        input int st, input logic [63:0] off_in_stall);
        in_valid = 1; in_data = $urandom; in_last = lst; in_eob = eob;
        in_has_time = ht; in_time = t;
        for (int i = 0; i < st; i++) begin
            out_ready = 0;
            cycle();
            if (i == 0) tx_offset = off_in_stall;
        end
        out_ready = 1;
        cycle();
        in_valid = 0; in_last = 0; in_eob = 0; in_has_time = 0;
    endtask

    task automatic packet(input int len, input bit eob, input bit ht, input logic [63:0] t,
                          input int stall_every);
        for (int k = 0; k < len; k++) begin
            int st;
            st = (stall_every > 0 && (k % stall_every) == 0) ? 2 : 0;
            beat(k == len-1, eob && (k == len-1), ht && (k == 0), t, st, tx_offset + 64'd3);
            if (k % 53 == 7) idle(1);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        tx_offset = 64'd1000;
        repeat (3) @(posedge clk);
        #1; rst = 0;
        // R9: reset state - first sample after reset carries no time, no last.
        in_valid = 1; out_ready = 0; in_has_time = 0;
        #1;
        chk(out_has_time == 0 && out_last == 0 && out_eob == 0, "R9 reset state",
            {out_has_time, out_last, out_eob}, 3'b000);
        in_valid = 0; #1;
        idle(2);

        // Long packet, splits at 256 and 512 (R2), stalls (R4), timestamp on first.
        packet(600, 0, 1, 64'h0000_0001_0000_0000, 37);
        // Next input packet starts mid output packet: time stays pending (R5).
        tx_offset = 64'd500;
        packet(40, 0, 1, 64'h0000_0000_0000_ABCD, 0);
        // in_eob without in_last has no effect (R3); then a burst end.
        beat(0, 1, 0, 0, 0, tx_offset);
        packet(30, 1, 1, 64'h55, 5);
        // Stalled stamped first sample, offset changed during stall (R8).
        beat(0, 0, 1, 64'h1234, 4, 64'd777777);
        packet(20, 1, 0, 0, 0);
        // 64-bit wrap of time + offset (R7).
        tx_offset = 64'd16;
        packet(10, 1, 1, 64'hFFFF_FFFF_FFFF_FFF8, 0);
        // Burst end landing exactly on the 256th sample.
        packet(256, 1, 1, 64'h42, 0);
        // Mid-packet reset with a pending time (R9).
        packet(5, 0, 1, 64'h99, 0);
        @(negedge clk); rst = 1; @(posedge clk); #1; rst = 0; model_reset();
        packet(300, 1, 0, 0, 11);
        idle(3);

        chk(stall_seen == 1, "R8 stall scenario reached", stall_seen, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule